// File: doc/BRIEF.md
# Packed-Byte Matrix Multiply Engine

This engine multiplies two square matrices of unsigned bytes and writes back a square matrix of bytes. All three matrices sit in their own single-port RAM of 32-bit words, with four byte elements packed into each word. The engine reads the two operand RAMs through its own RAM ports. It picks the required byte lanes out of each word, accumulates one result element at a time with a single multiply-accumulate datapath, and gathers four finished elements into a word before writing it to the result RAM.

A controller first fills the operand RAMs, then pulses `start`. The engine is busy until it pulses `done`, and by that cycle every result word has been written. The controller is a state machine with five states. ST_IDLE waits for start and moves to ST_STREAM on a start pulse. ST_STREAM issues one operand read pair per cycle across the reduction index and moves to ST_DRAIN after the last pair. ST_DRAIN takes in the last product, latches the finished byte into its lane of the pack register and clears the accumulator. From there it goes to ST_WRITE when the top lane has just been filled, and otherwise back to ST_STREAM for the next column. ST_WRITE stores the packed word. It returns to ST_STREAM for the next word, or moves to ST_DONE after the last word. ST_DONE pulses done and returns to ST_IDLE.

Top module: `mm_engine`

## Requirements
- R1: After reset, and in ST_IDLE with no start, `a_en`, `b_en`, `c_we` and `done` are all low.
- R2: Result element (i,k) equals the sum over j of A(i,j)*B(j,k), for i, j and k from 0 to 31, reduced modulo 256. For example, all-0xFF operands give 0x20 in every element.
- R3: Element (r,c) of every matrix is held in word r*8 + c/4, at byte lane c mod 4, and lane n occupies bits 8n+7:8n, so lane 0 is bits 7:0. For example, an identity A returns B unchanged.
- R4: Each run writes each of the 256 result words exactly once, in ascending address order, and each write carries all four finished elements. No operand read is issued in a write cycle.
- R5: `done` is high for exactly one cycle. It rises in the cycle right after the last result write.
- R6: A start pulse that arrives while a run is in progress is ignored. The run continues without restarting and its results are unchanged.
- R7: Every result element starts accumulating from zero. No partial sum carries over from a previous element or a previous run, so an all-zero A gives an all-zero result even right after a run with non-zero data.
- R8: Operand read data is taken one cycle after the matching enable. After `done`, a new start begins a fresh, correct run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only in ST_IDLE) |
| done | output | 1 | One-cycle pulse after the final result write |
| a_en | output | 1 | Read enable for the A RAM |
| a_addr | output | 8 | Word address in the A RAM |
| a_rdata | input | 32 | A RAM read data, one cycle after a_en |
| b_en | output | 1 | Read enable for the B RAM |
| b_addr | output | 8 | Word address in the B RAM |
| b_rdata | input | 32 | B RAM read data, one cycle after b_en |
| c_we | output | 1 | Write enable for the result RAM |
| c_addr | output | 8 | Word address in the result RAM |
| c_wdata | output | 32 | Packed result word |

## Verification
The hardest condition to reach from the ports is a start pulse that lands while a run is in progress. It only matters if the engine would otherwise restart its counters partway through the result. The bench therefore drives a second start pulse several hundred cycles into a random run. The write-order monitor would then see the address fall back to zero, and the final contents of the result RAM would be wrong. Wrap-around of the 8-bit sum is forced with all-0xFF operands. Lane placement is exposed by an identity A, and accumulator clearing by an all-zero A run straight after a non-zero run.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_WRITE,
        ST_DONE
    } mm_state_e;

endpackage

// File: rtl/mm_index_ctr.sv
// Row / column / reduction counters for the multiply walk.
module mm_index_ctr #(
    parameter int DIM   = 32,
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     step_j,
    input  logic                     clr_j,
    input  logic                     step_k,
    output logic [$clog2(DIM)-1:0]   row,
    output logic [$clog2(DIM)-1:0]   col,
    output logic [$clog2(DIM)-1:0]   red,
    output logic                     j_last,
    output logic                     lane_last,
    output logic                     all_last
);
    localparam int IW = $clog2(DIM);
    localparam int LW = $clog2(LANES);
    localparam logic [IW-1:0] LAST_IDX  = IW'(DIM - 1);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    logic [IW-1:0] i_q, k_q, j_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            i_q <= '0;
            k_q <= '0;
            j_q <= '0;
        end else begin
            if (clr_j) begin
                j_q <= '0;
            end else if (step_j) begin
                j_q <= j_q + 1'b1;
            end
            if (step_k) begin
                if (k_q == LAST_IDX) begin
                    k_q <= '0;
                    i_q <= i_q + 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    assign row       = i_q;
    assign col       = k_q;
    assign red       = j_q;
    assign j_last    = (j_q == LAST_IDX);
    assign lane_last = (k_q[LW-1:0] == LAST_LANE);
    assign all_last  = (i_q == LAST_IDX) && (k_q == LAST_IDX);

endmodule

// File: rtl/mm_lane_mac.sv
// Byte-lane selection from both operand words and a single multiply-accumulate.
module mm_lane_mac #(
    parameter int EW    = 8,
    parameter int WW    = 32,
    parameter int ACCW  = 21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          vld,
    input  logic [WW-1:0]                 a_word,
    input  logic [WW-1:0]                 b_word,
    input  logic [$clog2(WW/EW)-1:0]      a_lane,
    input  logic [$clog2(WW/EW)-1:0]      b_lane,
    output logic [EW-1:0]                 sum_now
);
    localparam int LANES = WW / EW;

    logic [EW-1:0]   a_bytes [LANES];
    logic [EW-1:0]   b_bytes [LANES];
    logic [2*EW-1:0] prod;
    logic [ACCW-1:0] acc_q;
    logic [ACCW-1:0] acc_next;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign a_bytes[g] = a_word[g*EW +: EW];
        assign b_bytes[g] = b_word[g*EW +: EW];
    end

    assign prod     = a_bytes[a_lane] * b_bytes[b_lane];
    assign acc_next = acc_q + (vld ? ACCW'(prod) : '0);
    assign sum_now  = acc_next[EW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/mm_packer.sv
// Collects finished result bytes into their lanes of one word.
module mm_packer #(
    parameter int EW = 8,
    parameter int WW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [$clog2(WW/EW)-1:0]  lane,
    input  logic [EW-1:0]             byte_in,
    output logic [WW-1:0]             word_out
);
    localparam int LANES = WW / EW;
    localparam int LW    = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        logic [EW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (load && (lane == LW'(g))) begin
                slot_q <= byte_in;
            end
        end
        assign word_out[g*EW +: EW] = slot_q;
    end

endmodule

// File: rtl/mm_engine.sv
// Packed-byte matrix multiply engine: top level and controller.
module mm_engine
    import mm_pkg::*;
#(
    parameter  int DIM = 32,
    parameter  int EW  = 8,
    parameter  int WW  = 32,
    localparam int AW  = $clog2(DIM * (DIM / (WW / EW)))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic          a_en,
    output logic [AW-1:0] a_addr,
    input  logic [WW-1:0] a_rdata,
    output logic          b_en,
    output logic [AW-1:0] b_addr,
    input  logic [WW-1:0] b_rdata,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic [WW-1:0] c_wdata
);
    localparam int LANES = WW / EW;
    localparam int LW    = $clog2(LANES);
    localparam int IW    = $clog2(DIM);
    localparam int ACCW  = 2 * EW + IW;

    mm_state_e state, nxt;

    logic clr_all, step_j, clr_j, step_k;
    logic rd_en, mac_clr, pack_load, wr_en, done_c;
    logic [IW-1:0] row, col, red;
    logic j_last, lane_last, all_last;
    logic rd_vld;
    logic [LW-1:0] a_lane_d;
    logic [EW-1:0] elem;
    logic [WW-1:0] packed_word;

    mm_index_ctr #(.DIM(DIM), .LANES(LANES)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .step_j    (step_j),
        .clr_j     (clr_j),
        .step_k    (step_k),
        .row       (row),
        .col       (col),
        .red       (red),
        .j_last    (j_last),
        .lane_last (lane_last),
        .all_last  (all_last)
    );

    mm_lane_mac #(.EW(EW), .WW(WW), .ACCW(ACCW)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mac_clr),
        .vld     (rd_vld),
        .a_word  (a_rdata),
        .b_word  (b_rdata),
        .a_lane  (a_lane_d),
        .b_lane  (col[LW-1:0]),
        .sum_now (elem)
    );

    mm_packer #(.EW(EW), .WW(WW)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pack_load),
        .lane     (col[LW-1:0]),
        .byte_in  (elem),
        .word_out (packed_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_STREAM;
            ST_STREAM: if (j_last) nxt = ST_DRAIN;
            ST_DRAIN:  nxt = lane_last ? ST_WRITE : ST_STREAM;
            ST_WRITE:  nxt = all_last ? ST_DONE : ST_STREAM;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Output / strobe decode
    always_comb begin
        clr_all   = 1'b0;
        step_j    = 1'b0;
        clr_j     = 1'b0;
        step_k    = 1'b0;
        rd_en     = 1'b0;
        mac_clr   = 1'b0;
        pack_load = 1'b0;
        wr_en     = 1'b0;
        done_c    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr_all = start;
                mac_clr = 1'b1;
            end
            ST_STREAM: begin
                rd_en  = 1'b1;
                step_j = !j_last;
            end
            ST_DRAIN: begin
                mac_clr   = 1'b1;
                pack_load = 1'b1;
                clr_j     = 1'b1;
                step_k    = !lane_last;
            end
            ST_WRITE: begin
                wr_en  = 1'b1;
                step_k = !all_last;
            end
            ST_DONE: begin
                done_c = 1'b1;
            end
            default: begin
                mac_clr = 1'b1;
            end
        endcase
    end

    // Read-data alignment: data returns one cycle after the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld   <= 1'b0;
            a_lane_d <= '0;
        end else begin
            rd_vld   <= rd_en;
            a_lane_d <= red[LW-1:0];
        end
    end

    assign a_en    = rd_en;
    assign b_en    = rd_en;
    assign a_addr  = {row, red[IW-1:LW]};
    assign b_addr  = {red, col[IW-1:LW]};
    assign c_we    = wr_en;
    assign c_addr  = {row, col[IW-1:LW]};
    assign c_wdata = packed_word;
    assign done    = done_c;

endmodule

// File: rtl/mm_engine_chk.sv
// Property checker attached to the engine.
module mm_engine_chk
    import mm_pkg::*;
#(
    parameter int AW    = 8,
    parameter int WORDS = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          a_en,
    input logic          b_en,
    input logic          c_we,
    input logic [AW-1:0] c_addr,
    input mm_state_e     state
);
    logic [AW:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            wr_cnt <= '0;
        end else if (c_we) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!a_en && !b_en && !c_we && !done)); // R1

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> (c_addr == wr_cnt[AW-1:0])); // R4

    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |-> (!a_en && !b_en)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_cnt == (AW+1)'(WORDS))); // R5

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(c_we)); // R5

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_STREAM) |=> (state != ST_IDLE)); // R6

endmodule

bind mm_engine mm_engine_chk #(
    .AW    (AW),
    .WORDS (DIM * DIM / (WW / EW))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .a_en   (a_en),
    .b_en   (b_en),
    .c_we   (c_we),
    .c_addr (c_addr),
    .state  (state)
);

// File: tb/tb_mm_engine.sv
module tb_mm_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIM   = 32;
    localparam int EW    = 8;
    localparam int WW    = 32;
    localparam int LANES = WW / EW;
    localparam int WPR   = DIM / LANES;
    localparam int WORDS = DIM * WPR;
    localparam int AW    = $clog2(WORDS);
    localparam int BW    = $clog2(WW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic          a_en, b_en, c_we;
    logic [AW-1:0] a_addr, b_addr, c_addr;
    logic [WW-1:0] a_rdata, b_rdata, c_wdata;

    logic [WW-1:0] mem_a [WORDS];
    logic [WW-1:0] mem_b [WORDS];
    logic [WW-1:0] mem_c [WORDS];
    logic [WW-1:0] exp_c [WORDS];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wexp = 0;
    int last_wr_cyc = -10;
    bit prev_done = 1'b0;

    mm_engine #(.DIM(DIM), .EW(EW), .WW(WW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .done    (done),
        .a_en    (a_en),
        .a_addr  (a_addr),
        .a_rdata (a_rdata),
        .b_en    (b_en),
        .b_addr  (b_addr),
        .b_rdata (b_rdata),
        .c_we    (c_we),
        .c_addr  (c_addr),
        .c_wdata (c_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // RAM models with one cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (a_en) a_rdata <= mem_a[a_addr];
        if (b_en) b_rdata <= mem_b[b_addr];
        if (c_we) mem_c[c_addr] <= c_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [EW-1:0] lane_of(input logic [WW-1:0] w, input int lane);
        return w[BW'(lane*EW) +: EW];
    endfunction

    // Write-order and done monitor, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (c_we) begin
                chk(c_addr == AW'(wexp), "R4 write order", 32'(c_addr), 32'(wexp));
                chk(!a_en && !b_en, "R4 no read during write", {30'd0, a_en, b_en}, 32'd0);
                wexp++;
                last_wr_cyc = cyc;
            end
            if (done) begin
                chk(wexp == WORDS, "R4 words per run", 32'(wexp), 32'(WORDS));
                chk(last_wr_cyc == cyc - 1, "R5 done follows last write", 32'(cyc - last_wr_cyc), 32'd1);
                chk(!prev_done, "R5 done single cycle", 32'(prev_done), 32'd0);
                wexp = 0;
            end
            prev_done = done;
        end
    end

    task automatic compute_expected();
        for (int r = 0; r < DIM; r++) begin
            for (int c = 0; c < DIM; c++) begin
                logic [EW-1:0] s;
                s = '0;
                for (int j = 0; j < DIM; j++) begin
                    logic [EW-1:0] av, bv;
                    av = lane_of(mem_a[AW'(r*WPR + j/LANES)], j % LANES);
                    bv = lane_of(mem_b[AW'(j*WPR + c/LANES)], c % LANES);
                    s = EW'(s + av * bv);
                end
                exp_c[AW'(r*WPR + c/LANES)][BW'((c%LANES)*EW) +: EW] = s;
            end
        end
    endtask

    task automatic do_run(input string req, input bit mid_start);
        compute_expected();
        for (int w = 0; w < WORDS; w++) mem_c[w] = 32'hDEAD_BEEF;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (500) @(negedge clk);
            start = 1'b1;          // R6: start while busy
            @(negedge clk); start = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk(!done, "R5 done low after pulse", 32'(done), 32'd0);
        for (int w = 0; w < WORDS; w++) begin
            chk(mem_c[w] == exp_c[w], req, mem_c[w], exp_c[w]);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!a_en && !b_en && !c_we && !done, "R1 outputs in reset",
            {28'd0, a_en, b_en, c_we, done}, 32'd0);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!a_en && !b_en && !c_we && !done, "R1 idle without start",
                {28'd0, a_en, b_en, c_we, done}, 32'd0);
        end

        // Run 1: random operands with a start pulse mid-run (R2, R6)
        for (int w = 0; w < WORDS; w++) begin
            mem_a[w] = $urandom();
            mem_b[w] = $urandom();
        end
        do_run("R6 R2 random result", 1'b1);

        // Run 2: all 0xFF, sum wraps modulo 256 to 0x20 (R2, R8)
        for (int w = 0; w < WORDS; w++) begin
            mem_a[w] = 32'hFFFF_FFFF;
            mem_b[w] = 32'hFFFF_FFFF;
        end
        do_run("R2 R8 wrap all-ones", 1'b0);
        chk(exp_c[0] == 32'h2020_2020, "R2 wrap model", exp_c[0], 32'h2020_2020);

        // Run 3: zero A after non-zero run, result must be zero (R7)
        for (int w = 0; w < WORDS; w++) begin
            mem_a[w] = '0;
            mem_b[w] = $urandom();
        end
        do_run("R7 cleared accumulation", 1'b0);

        // Run 4: identity A returns B, exposing lane placement (R3)
        for (int w = 0; w < WORDS; w++) mem_a[w] = '0;
        for (int r = 0; r < DIM; r++) begin
            mem_a[AW'(r*WPR + r/LANES)][BW'((r%LANES)*EW) +: EW] = 8'd1;
        end
        for (int w = 0; w < WORDS; w++) mem_b[w] = $urandom();
        do_run("R3 identity lanes", 1'b0);
        for (int w = 0; w < WORDS; w += 37) begin
            chk(mem_c[w] == mem_b[w], "R3 identity equals B", mem_c[w], mem_b[w]);
        end

        report();
    end

endmodule